// File: doc/BRIEF.md
# Change-Only Sample Cluster Writer

This block turns a stream of 16-bit sample words, one per sample tick, into a compressed record in a word-wide sample memory. A word is stored only when it differs from the one on the previous tick. Stored words are grouped into clusters of eight memory words. The first word of a cluster is a timestamp, and the remaining seven are event words taken on consecutive ticks. The first event of a cluster belongs to the tick named by its timestamp, and each later event is one tick after the one before it.

A run of changes ends at the first tick that repeats the previous value, or when the seventh event is stored. The next change then opens a new cluster with a fresh timestamp. If no cluster has been opened for nearly a whole timestamp period, the block opens one on the current value even though nothing changed. This means any reader can resolve timestamp rollover. Each finished cluster is written as a burst of eight words to consecutive addresses. Unused event slots are filled with the last real event, and a side output gives the number of real events. The current write position is visible at all times so that trigger logic can record it.

Top module: `delta_cluster_packer`

## Requirements
- R1: After reset the block writes nothing and `wr_pos` is 0. The first tick after reset always opens a cluster with timestamp 0, whatever its sample value.
- R2: A closed cluster is written as eight back-to-back single-cycle writes at in-cluster offsets 0 to 7. For a cluster closed by the tick sampled at clock edge E, `mem_we` is low in the cycle after E, and offset 0 is presented in the cycle after edge E+1.
- R3: Offset 0 holds the timestamp with its low byte in bits [15:8] and its high byte in bits [7:0]. Offsets 1 to 7 hold events exactly as sampled, with the high byte in bits [15:8].
- R4: A tick whose sample equals the previous tick's sample stores no event. A differing tick while a cluster is open appends an event in the next slot.
- R5: A repeated sample closes the open cluster. The next differing tick opens a new cluster whose timestamp is that tick's index (ticks counted from 0 after reset, modulo 2^TS_W).
- R6: A cluster closes as soon as its seventh event is stored. A later change opens a new cluster.
- R7: Event slots beyond the real ones repeat the last real event. `mem_nvalid`, valid while `mem_we` is high, gives the real count (1 to 7).
- R8: If 2^TS_W-1 ticks pass after the last cluster opened without another opening, that tick opens a cluster on its current sample, even if the sample is unchanged.
- R9: The address is {row, word-in-row}, with COL_W in-row bits. Clusters are placed one after another at a stride of 8 words, so a row holds 2^COL_W/8 clusters. After the last cluster of the last row, writing wraps to address 0.
- R10: `wr_pos` is the address that the next cluster's timestamp word will be written to.
- R11: `smp_valid` is high for at most one cycle in any four consecutive cycles. Under that rule, clusters that close on back-to-back opportunities are all written intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample tick strobe |
| smp_data | input | 16 | Sample word for this tick |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ROW_W+COL_W | Word address {row, word-in-row} |
| mem_wdata | output | 16 | Word to write |
| mem_nvalid | output | 3 | Real event count of the cluster being written |
| wr_pos | output | ROW_W+COL_W | Start address of the next cluster |

## Verification
The assertions assume that sample ticks are at least four cycles apart. Under that condition, the burst of a cluster can never be overrun by the hand-over of the next one. The assertions also assume that an open cluster never lives long enough to meet the forced-cluster point, which holds for any TS_W of 4 or more. The bench drives every tick through one task that holds the strobe for a single cycle and then waits three idle cycles. The bench uses a 10-bit timestamp and a single row bit, so that rollover forcing, nonzero high timestamp bytes and address wrap can all be reached within a short run.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
    localparam int WORD_W   = 16;
    localparam int EV_N     = 7;
    localparam int CNT_W    = 3;
    localparam int OFS_W    = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t                ts;
        word_t [EV_N-1:0]     ev;
        logic  [CNT_W-1:0]    cnt;
    } cluster_t;

    // Timestamp leaves with its low byte in the upper lane.
    function automatic word_t ts_word(input word_t ts);
        return {ts[7:0], ts[15:8]};
    endfunction
endpackage

// File: rtl/dcp_builder.sv
module dcp_builder
    import dcp_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  word_t    din,
    output logic     seal,
    output cluster_t cl
);
    localparam logic [TS_W-1:0] FORCE_AT = {{(TS_W-1){1'b1}}, 1'b0};

    logic            open_q;
    logic            first_q;
    word_t           prev_q;
    logic [TS_W-1:0] tick_ctr;
    logic [TS_W-1:0] since_q;
    logic [1:0]      gap_q;

    logic changed, force_now;
    assign changed   = first_q || (din != prev_q);
    assign force_now = !first_q && (since_q == FORCE_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            first_q  <= 1'b1;
            prev_q   <= '0;
            tick_ctr <= '0;
            since_q  <= '0;
            seal     <= 1'b0;
            cl       <= '0;
            gap_q    <= 2'd3;
        end else begin
            seal <= 1'b0;
            if (tick) gap_q <= 2'd0;
            else if (gap_q != 2'd3) gap_q <= gap_q + 2'd1;
            if (tick) begin
                prev_q   <= din;
                first_q  <= 1'b0;
                tick_ctr <= tick_ctr + 1'b1;
                if (open_q) begin
                    since_q <= since_q + 1'b1;
                    if (changed) begin
                        for (int j = 0; j < EV_N; j++)
                            if (j >= int'(cl.cnt)) cl.ev[j] <= din;
                        cl.cnt <= cl.cnt + 1'b1;
                        if (int'(cl.cnt) == EV_N - 1) begin
                            open_q <= 1'b0;
                            seal   <= 1'b1;
                        end
                    end else begin
                        open_q <= 1'b0;
                        seal   <= 1'b1;
                    end
                end else if (changed || force_now) begin
                    open_q  <= 1'b1;
                    since_q <= '0;
                    cl.ts   <= word_t'(tick_ctr);
                    for (int j = 0; j < EV_N; j++) cl.ev[j] <= din;
                    cl.cnt  <= CNT_W'(1);
                end else begin
                    since_q <= since_q + 1'b1;
                end
            end
        end
    end

    // R11: input rule, ticks at least four cycles apart
    p_tick_gap_r11: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == 2'd3);
    // R6: an open cluster never holds a full set of events
    p_open_count_r6: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (cl.cnt >= CNT_W'(1)) && (int'(cl.cnt) < EV_N));
    // R4/R5: a repeated sample ends an open run
    p_repeat_closes_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && open_q && !first_q && din == prev_q) |=> (!open_q && seal));
    // R8: quiet span reaching the limit opens a cluster
    p_force_open_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !open_q && force_now) |=> (open_q && cl.cnt == CNT_W'(1)));
endmodule

// File: rtl/dcp_emitter.sv
module dcp_emitter
    import dcp_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   seal,
    input  cluster_t               cl_in,
    output logic                   mem_we,
    output logic [PTR_W+OFS_W-1:0] mem_addr,
    output word_t                  mem_wdata,
    output logic [CNT_W-1:0]       mem_nvalid,
    output logic [PTR_W+OFS_W-1:0] wr_pos
);
    localparam logic [OFS_W-1:0] LAST = '1;

    logic             busy;
    logic [OFS_W-1:0] ofs;
    logic [PTR_W-1:0] ptr;
    cluster_t         sh;
    logic [OFS_W-1:0] ev_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ofs  <= '0;
            ptr  <= '0;
            sh   <= '0;
        end else begin
            if (busy && ofs == LAST) ptr <= ptr + 1'b1;
            if (seal) begin
                sh   <= cl_in;
                busy <= 1'b1;
                ofs  <= '0;
            end else if (busy) begin
                ofs <= ofs + 1'b1;
                if (ofs == LAST) busy <= 1'b0;
            end
        end
    end

    assign ev_idx     = (ofs == '0) ? '0 : ofs - 1'b1;
    assign mem_we     = busy;
    assign mem_addr   = {ptr, ofs};
    assign mem_wdata  = (ofs == '0) ? ts_word(sh.ts) : sh.ev[ev_idx];
    assign mem_nvalid = sh.cnt;
    assign wr_pos     = {ptr, {OFS_W{1'b0}}};

    // R2: a new cluster never arrives mid-burst
    p_no_overrun_r2: assert property (@(posedge clk) disable iff (rst)
        seal |-> (!busy || ofs == LAST));
    // R2: burst words follow one per cycle
    p_burst_step_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && ofs != LAST) |=> (busy && ofs == $past(ofs) + 1'b1));
    // R9: cluster slot advances by one after each burst, wrapping
    p_slot_step_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && ofs == LAST) |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/delta_cluster_packer.sv
module delta_cluster_packer
    import dcp_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int ROW_W = 15,
    parameter int COL_W = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_valid,
    input  logic [15:0]            smp_data,
    output logic                   mem_we,
    output logic [ROW_W+COL_W-1:0] mem_addr,
    output logic [15:0]            mem_wdata,
    output logic [2:0]             mem_nvalid,
    output logic [ROW_W+COL_W-1:0] wr_pos
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PTR_W  = ADDR_W - OFS_W;

    logic     seal;
    cluster_t cl;

    dcp_builder #(.TS_W(TS_W)) u_build (
        .clk  (clk),
        .rst  (rst),
        .tick (smp_valid),
        .din  (smp_data),
        .seal (seal),
        .cl   (cl)
    );

    dcp_emitter #(.PTR_W(PTR_W)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .seal       (seal),
        .cl_in      (cl),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_nvalid (mem_nvalid),
        .wr_pos     (wr_pos)
    );

    // R1: nothing is written while nothing has been sealed
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(seal));
endmodule

// File: tb/test_delta_cluster_packer.sv
module test_delta_cluster_packer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [15:0]   smp_data = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [2:0]    mem_nvalid;
    logic [AW-1:0] wr_pos;

    delta_cluster_packer #(.TS_W(10), .ROW_W(1), .COL_W(9)) i_delta_cluster_packer (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_nvalid(mem_nvalid), .wr_pos(wr_pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int tick_no = 0;
    int wr_total = 0;
    logic [15:0] shadow [0:1023];
    logic [2:0]  nv [0:127];

    always @(negedge clk) if (mem_we) begin
        shadow[mem_addr] = mem_wdata;
        nv[mem_addr[9:3]] = mem_nvalid;
        wr_total++;
    end

    function automatic logic [15:0] swp(input int t);
        logic [15:0] v = 16'(t % 1024);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic [15:0] v);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0; tick_no++;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 we after reset", 32'(mem_we), 0);
        chk("R1 wr_pos after reset", 32'(wr_pos), 0);
    endtask

    // First cluster with burst timing: tick0 opens, tick1 repeats and closes.
    task automatic t_first_burst();
        do_tick(16'h1234);
        smp_valid = 1'b1; smp_data = 16'h1234;
        @(negedge clk);
        smp_valid = 1'b0; tick_no++;
        chk("R2 no write right after closing tick", 32'(mem_we), 0);
        @(negedge clk);
        chk("R2 burst start we", 32'(mem_we), 1);
        chk("R2 burst start addr", 32'(mem_addr), 0);
        chk("R1 first timestamp 0", 32'(mem_wdata), 32'(swp(0)));
        repeat (7) @(negedge clk);
        chk("R2 burst end addr", 32'(mem_addr), 7);
        chk("R7 last pad word", 32'(mem_wdata), 32'h1234);
        @(negedge clk);
        chk("R2 burst over", 32'(mem_we), 0);
        drain();
        chk("R3 event word", 32'(shadow[1]), 32'h1234);
        chk("R7 single real event", 32'(nv[0]), 1);
        chk("R10 wr_pos after one cluster", 32'(wr_pos), 8);
    endtask

    // Repeat stores nothing; change opens, change appends, repeat closes.
    task automatic t_runs();
        int w0;
        w0 = wr_total;
        do_tick(16'h1234);
        drain();
        chk("R4 repeated sample writes nothing", 32'(wr_total), 32'(w0));
        do_tick(16'hBEEF);
        do_tick(16'hC0DE);
        do_tick(16'hC0DE);
        drain();
        chk("R5 new timestamp", 32'(shadow[8]), 32'(swp(3)));
        chk("R4 first event", 32'(shadow[9]), 32'hBEEF);
        chk("R4 appended event", 32'(shadow[10]), 32'hC0DE);
        chk("R7 padding repeats last", 32'(shadow[15]), 32'hC0DE);
        chk("R7 two real events", 32'(nv[1]), 2);
    endtask

    // Seven changes fill a cluster; the next change opens another.
    task automatic t_full();
        for (int k = 0; k < 7; k++) do_tick(16'h0100 + 16'(k));
        do_tick(16'h7E7E);
        do_tick(16'h7E7E);
        drain();
        chk("R6 full cluster timestamp", 32'(shadow[16]), 32'(swp(6)));
        chk("R6 first of seven", 32'(shadow[17]), 32'h0100);
        chk("R6 seventh event", 32'(shadow[23]), 32'h0106);
        chk("R7 seven real events", 32'(nv[2]), 7);
        chk("R6 next cluster timestamp", 32'(shadow[24]), 32'(swp(13)));
        chk("R6 next cluster event", 32'(shadow[25]), 32'h7E7E);
    endtask

    // Timestamp with a nonzero high byte.
    task automatic t_byte_order();
        while (tick_no < 421) do_tick(16'h7E7E);
        do_tick(16'hA0B1);
        do_tick(16'hA0B1);
        drain();
        chk("R3 timestamp byte order", 32'(shadow[32]), 32'hA501);
        chk("R3 event byte order", 32'(shadow[33]), 32'hA0B1);
    endtask

    // Quiet line: forced cluster 1023 ticks after the last opening (tick 421).
    task automatic t_force();
        int w0;
        w0 = wr_total;
        while (tick_no < 1444) do_tick(16'hA0B1);
        drain();
        chk("R8 no cluster before limit", 32'(wr_total), 32'(w0));
        do_tick(16'hA0B1);
        do_tick(16'hA0B1);
        drain();
        chk("R8 forced timestamp", 32'(shadow[40]), 32'(swp(1444)));
        chk("R8 forced event", 32'(shadow[41]), 32'hA0B1);
        chk("R8 forced count", 32'(nv[5]), 1);
        chk("R10 wr_pos after forced", 32'(wr_pos), 48);
    endtask

    // Back-to-back clusters across the row boundary and the memory wrap.
    task automatic t_wrap();
        int ts64 = 0;
        for (int k = 6; k < 128; k++) begin
            if (k == 64) ts64 = tick_no;
            do_tick(16'h4000 + 16'(k));
            do_tick(16'h4000 + 16'(k));
        end
        drain();
        chk("R9 second row start ts", 32'(shadow[512]), 32'(swp(ts64)));
        chk("R11 back-to-back cluster event", 32'(shadow[513]), 32'h4040);
        chk("R11 back-to-back pad", 32'(shadow[1023]), 32'h407F);
        chk("R10 wr_pos wraps to 0", 32'(wr_pos), 0);
        ts64 = tick_no;
        do_tick(16'h7777);
        do_tick(16'h7777);
        drain();
        chk("R9 wrapped ts at 0", 32'(shadow[0]), 32'(swp(ts64)));
        chk("R9 wrapped event at 1", 32'(shadow[1]), 32'h7777);
        chk("R10 wr_pos after wrap", 32'(wr_pos), 8);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_burst();
        t_runs();
        t_full();
        t_byte_order();
        t_force();
        t_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule